// File: doc/BRIEF.md
# Timing-Error-Drop MAC Column

This block is one column of a weight-stationary systolic array. It is built from multiply-accumulate processing elements. Each element holds a signed weight and multiplies it with the activation arriving from its left. It adds the product to the partial sum coming from above and passes activation and sum onward: the activation to the right, the sum downward.

Every element registers its result twice. A main register models the normal clock edge. A shadow register models a capture half a period later, which always holds the settled value. A mismatch between the two copies is a timing error. The element never repeats the faulty operation and never holds the array. Instead it forwards the shadow copy, which is the correct sum. It also raises a bypass flag that travels with that sum. The element below sees the flag and passes the sum through unchanged, so its own product is dropped for that one operation.

The late-settling path is modelled in a single clock domain. A per-row test input flips fixed bits of the main copy for one operation. Activations, test inputs and the top bypass flag are entered as one vector. The column skews them internally, so a whole vector meets its own partial-sum wavefront. Each element keeps a saturating count of the errors it has detected, for monitoring the error rate.

Top module: `tedrop_column`

## Requirements
- R1: A vector accepted with `in_valid` high at a clock edge appears on `col_psum_out` with `col_valid_out` high exactly NUM_PE edges later. Its value is `col_psum_in` + Σk w[k]·a[k], modulo 2^ACC_W. Row k uses activation bits [k*DATA_W +: DATA_W] and weight bits [k*DATA_W +: DATA_W], both signed two's complement.
- R2: `act_out` row k (bits [k*DATA_W +: DATA_W]) equals `act_in` row k from k+1 edges earlier. This holds whether or not the vector is valid, injected or bypassed.
- R3: If `inj_in[k]` is set on a valid vector, for k below NUM_PE-1, then element k still forwards its correct sum. The contribution of element k+1 is omitted from the result, and every other contribution is kept.
- R4: An injection on the last element leaves the result complete. `col_drop_out` is high in the same cycle as that result.
- R5: `col_drop_in` high with a valid vector omits the contribution of element 0.
- R6: The column accepts a vector on every cycle. Results leave in issue order, one per cycle, and errors never delay or shift any neighbouring result.
- R7: Bits [k*CNT_W +: CNT_W] of `err_cnt_out` count the errors detected by element k, one per error. The count saturates at 2^CNT_W-1.
- R8: `inj_in` and `col_drop_in` given while `in_valid` is low have no effect: counts, `col_valid_out` and `col_drop_out` stay unchanged.
- R9: After reset `col_valid_out`, `col_drop_out`, `col_psum_out` and all error counts are zero.
- R10: Weights written with `wt_load` high at an edge apply to every vector accepted after that edge, including the extreme value -2^(DATA_W-1).
- R11: A bypass flag leaves an element only in the cycle after that element took an injected valid operation. Vectors without injection never raise `col_drop_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_load | input | 1 | Write `wt_in` into the stationary weights |
| wt_in | input | NUM_PE*DATA_W | Weights, one signed field per row |
| in_valid | input | 1 | The vector on `act_in` is valid |
| act_in | input | NUM_PE*DATA_W | Activation vector, one signed field per row |
| inj_in | input | NUM_PE | Force a main/shadow mismatch in row k for this vector |
| col_psum_in | input | ACC_W | Partial sum entering the top of the column |
| col_drop_in | input | 1 | Bypass request entering the top element |
| col_valid_out | output | 1 | Result valid |
| col_psum_out | output | ACC_W | Column result |
| col_drop_out | output | 1 | Last element detected an error, so the consumer should drop the next contribution |
| act_out | output | NUM_PE*DATA_W | Activations passed to the right |
| err_cnt_out | output | NUM_PE*CNT_W | Saturating error counts, one field per element |

## Verification
A stale main or shadow copy, or a bypass flag that is late or missing, shows up on `col_psum_out` for the affected vector exactly NUM_PE edges after issue. The result is then off by one product, or it still carries the injected bit flips. The bench issues a vector on every cycle. A flag that lingers, or a sum that slips by one stage, therefore corrupts the next result too. A wrong counter shows up on `err_cnt_out` within two edges of the error. A broken activation register shows up on `act_out` after k+1 edges.

// File: rtl/tedrop_pkg.sv
package tedrop_pkg;
    localparam int unsigned DEF_NUM_PE = 4;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_ACC_W  = 24;
    localparam int unsigned DEF_CNT_W  = 4;
endpackage

// File: rtl/tedrop_skew.sv
module tedrop_skew #(
    parameter int unsigned W     = 9,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef logic [W-1:0] stage_t;

    stage_t line_d [DEPTH];
    stage_t line_q [DEPTH];

    always_comb begin
        line_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            line_d[i] = line_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            line_q <= line_d;
        end
    end

    assign dout = line_q[DEPTH-1];
endmodule

// File: rtl/tedrop_pe.sv
module tedrop_pe #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ACC_W  = 24,
    parameter int unsigned CNT_W  = 4,
    parameter logic [ACC_W-1:0] INJ_MASK = {1'b1, {(ACC_W-2){1'b0}}, 1'b1}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_load,
    input  logic [DATA_W-1:0] wt_in,
    input  logic [DATA_W-1:0] act_in,
    input  logic              inj_in,
    input  logic              valid_in,
    input  logic [ACC_W-1:0]  psum_in,
    input  logic              drop_in,
    output logic [DATA_W-1:0] act_out,
    output logic              valid_out,
    output logic [ACC_W-1:0]  psum_out,
    output logic              drop_out,
    output logic [CNT_W-1:0]  err_cnt
);
    localparam int unsigned PROD_W = 2 * DATA_W;
    localparam int unsigned EXT_W  = ACC_W - PROD_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [DATA_W-1:0] wt;
        logic [DATA_W-1:0] act;
        logic              valid;
        logic [ACC_W-1:0]  main;
        logic [ACC_W-1:0]  shadow;
        logic [CNT_W-1:0]  cnt;
    } pe_state_t;

    pe_state_t st_d, st_q;

    logic                     mismatch;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         prod_ext;
    logic [ACC_W-1:0]         mac_val;
    logic [ACC_W-1:0]         flip;

    always_comb begin
        // error flag: any bit differing between the two captured copies
        mismatch = |(st_q.main ^ st_q.shadow);

        prod     = $signed(act_in) * $signed(st_q.wt);
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

        // a bypassed element passes the forwarded sum through untouched
        mac_val  = drop_in ? psum_in : psum_in + prod_ext;

        // late-settling path model: main copy captures disturbed bits
        flip     = (inj_in && valid_in) ? INJ_MASK : '0;

        st_d        = st_q;
        st_d.act    = act_in;
        st_d.valid  = valid_in;
        st_d.main   = mac_val ^ flip;
        st_d.shadow = mac_val;
        if (wt_load) begin
            st_d.wt = wt_in;
        end
        if (mismatch && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_out   = st_q.act;
    assign valid_out = st_q.valid;
    assign psum_out  = mismatch ? st_q.shadow : st_q.main;
    assign drop_out  = mismatch;
    assign err_cnt   = st_q.cnt;
endmodule

// File: rtl/tedrop_column.sv
module tedrop_column
    import tedrop_pkg::*;
#(
    parameter int unsigned NUM_PE = DEF_NUM_PE,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ACC_W  = DEF_ACC_W,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wt_load,
    input  logic [NUM_PE*DATA_W-1:0] wt_in,
    input  logic                     in_valid,
    input  logic [NUM_PE*DATA_W-1:0] act_in,
    input  logic [NUM_PE-1:0]        inj_in,
    input  logic [ACC_W-1:0]         col_psum_in,
    input  logic                     col_drop_in,
    output logic                     col_valid_out,
    output logic [ACC_W-1:0]         col_psum_out,
    output logic                     col_drop_out,
    output logic [NUM_PE*DATA_W-1:0] act_out,
    output logic [NUM_PE*CNT_W-1:0]  err_cnt_out
);
    localparam int unsigned SKEW_W = DATA_W + 1;

    logic [NUM_PE:0]             vld_chain;
    logic [NUM_PE:0]             drop_chain;
    logic [(NUM_PE+1)*ACC_W-1:0] psum_chain;
    logic [NUM_PE*DATA_W-1:0]    act_pe;
    logic [NUM_PE-1:0]           inj_pe;

    assign vld_chain[0]          = in_valid;
    assign drop_chain[0]         = col_drop_in;
    assign psum_chain[ACC_W-1:0] = col_psum_in;

    generate
        for (genvar k = 0; k < NUM_PE; k++) begin : g_row
            if (k == 0) begin : g_noskew
                assign act_pe[DATA_W-1:0] = act_in[DATA_W-1:0];
                assign inj_pe[0]          = inj_in[0];
            end else begin : g_skew
                logic [SKEW_W-1:0] skew_out;
                tedrop_skew #(
                    .W    (SKEW_W),
                    .DEPTH(k)
                ) skew_i (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .din  ({inj_in[k], act_in[k*DATA_W +: DATA_W]}),
                    .dout (skew_out)
                );
                assign act_pe[k*DATA_W +: DATA_W] = skew_out[DATA_W-1:0];
                assign inj_pe[k]                  = skew_out[DATA_W];
            end

            tedrop_pe #(
                .DATA_W(DATA_W),
                .ACC_W (ACC_W),
                .CNT_W (CNT_W)
            ) pe_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .wt_load  (wt_load),
                .wt_in    (wt_in[k*DATA_W +: DATA_W]),
                .act_in   (act_pe[k*DATA_W +: DATA_W]),
                .inj_in   (inj_pe[k]),
                .valid_in (vld_chain[k]),
                .psum_in  (psum_chain[k*ACC_W +: ACC_W]),
                .drop_in  (drop_chain[k]),
                .act_out  (act_out[k*DATA_W +: DATA_W]),
                .valid_out(vld_chain[k+1]),
                .psum_out (psum_chain[(k+1)*ACC_W +: ACC_W]),
                .drop_out (drop_chain[k+1]),
                .err_cnt  (err_cnt_out[k*CNT_W +: CNT_W])
            );
        end
    endgenerate

    assign col_valid_out = vld_chain[NUM_PE];
    assign col_psum_out  = psum_chain[NUM_PE*ACC_W +: ACC_W];
    assign col_drop_out  = drop_chain[NUM_PE];
endmodule

// File: rtl/tedrop_column_chk.sv
module tedrop_column_chk #(
    parameter int unsigned NUM_PE = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ACC_W  = 24,
    parameter int unsigned CNT_W  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_PE:0]          vld_chain,
    input logic [NUM_PE:0]          drop_chain,
    input logic [(NUM_PE+1)*ACC_W-1:0] psum_chain,
    input logic [NUM_PE*DATA_W-1:0] act_pe,
    input logic [NUM_PE-1:0]        inj_pe,
    input logic [NUM_PE*DATA_W-1:0] act_out,
    input logic [NUM_PE*CNT_W-1:0]  err_cnt_out
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    generate
        for (genvar k = 0; k < NUM_PE; k++) begin : g_chk
            // R3 / R5: a bypassed element hands the incoming sum on unchanged
            a_r3_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
                (drop_chain[k] && vld_chain[k]) |=>
                    (psum_chain[(k+1)*ACC_W +: ACC_W] == $past(psum_chain[k*ACC_W +: ACC_W])));

            // R11: an error flag only follows an injected valid operation
            a_r11_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && drop_chain[k+1]) |-> $past(inj_pe[k] && vld_chain[k]));

            // R2: activations move one register to the right
            a_r2_act_shift: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |->
                    (act_out[k*DATA_W +: DATA_W] == $past(act_pe[k*DATA_W +: DATA_W])));

            // R7: a count changes only by a single step upward
            a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && (err_cnt_out[k*CNT_W +: CNT_W] != $past(err_cnt_out[k*CNT_W +: CNT_W]))) |->
                    ({1'b0, err_cnt_out[k*CNT_W +: CNT_W]} ==
                     {1'b0, $past(err_cnt_out[k*CNT_W +: CNT_W])} + 1'b1));

            // R7: every detected error below saturation is counted
            a_r7_cnt_counts: assert property (@(posedge clk) disable iff (!rst_n)
                (drop_chain[k+1] && (err_cnt_out[k*CNT_W +: CNT_W] != CMAX)) |=>
                    (err_cnt_out[k*CNT_W +: CNT_W] == $past(err_cnt_out[k*CNT_W +: CNT_W]) + 1'b1));
        end
    endgenerate
endmodule

bind tedrop_column tedrop_column_chk #(
    .NUM_PE(NUM_PE),
    .DATA_W(DATA_W),
    .ACC_W (ACC_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld_chain  (vld_chain),
    .drop_chain (drop_chain),
    .psum_chain (psum_chain),
    .act_pe     (act_pe),
    .inj_pe     (inj_pe),
    .act_out    (act_out),
    .err_cnt_out(err_cnt_out)
);

// File: tb/tedrop_column_tb_top.sv
`timescale 1ns/1ps
module tedrop_column_tb_top;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int AW = 24;
    localparam int CW = 4;
    localparam int HIST = 4096;
    localparam int CMAX = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wt_load = 1'b0;
    logic [N*DW-1:0] wt_in = '0;
    logic            in_valid = 1'b0;
    logic [N*DW-1:0] act_in = '0;
    logic [N-1:0]    inj_in = '0;
    logic [AW-1:0]   col_psum_in = '0;
    logic            col_drop_in = 1'b0;
    logic            col_valid_out;
    logic [AW-1:0]   col_psum_out;
    logic            col_drop_out;
    logic [N*DW-1:0] act_out;
    logic [N*CW-1:0] err_cnt_out;

    tedrop_column #(.NUM_PE(N), .DATA_W(DW), .ACC_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_in(wt_in),
        .in_valid(in_valid), .act_in(act_in), .inj_in(inj_in),
        .col_psum_in(col_psum_in), .col_drop_in(col_drop_in),
        .col_valid_out(col_valid_out), .col_psum_out(col_psum_out),
        .col_drop_out(col_drop_out), .act_out(act_out), .err_cnt_out(err_cnt_out)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [AW-1:0]   exp_sum  [HIST];
    bit              exp_vld  [HIST];
    bit              exp_drop [HIST];
    string           exp_tag  [HIST];
    logic [N*DW-1:0] act_hist [HIST];
    int              wmodel   [N];
    int              cnt_exp  [N];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [AW-1:0] model_sum(input logic [N*DW-1:0] a, input logic [N-1:0] inj,
                                                 input bit din, input logic [AW-1:0] ps);
        int  s;
        bit  dropped;
        s = int'(ps);
        dropped = din;
        for (int k = 0; k < N; k++) begin
            if (!dropped) s += wmodel[k] * int'($signed(a[k*DW +: DW]));
            dropped = inj[k];
        end
        return s[AW-1:0];
    endfunction

    task automatic check_outputs();
        if (cyc >= N) begin
            int idx = cyc - N;
            if (exp_vld[idx]) begin
                check(col_valid_out == 1'b1, {exp_tag[idx], " valid"}, col_valid_out, 1);
                check(col_psum_out == exp_sum[idx], {exp_tag[idx], " sum"}, col_psum_out, exp_sum[idx]);
                check(col_drop_out == exp_drop[idx], {exp_tag[idx], "/R11 drop"}, col_drop_out, exp_drop[idx]);
            end else begin
                check(col_valid_out == 1'b0, "R8 idle valid", col_valid_out, 0);
                check(col_drop_out == 1'b0, "R8 idle drop", col_drop_out, 0);
            end
        end
        for (int k = 0; k < N; k++) begin
            if (cyc >= k + 1) begin
                logic [DW-1:0] ea = act_hist[cyc-k-1][k*DW +: DW];
                check(act_out[k*DW +: DW] == ea, "R2 act pass", act_out[k*DW +: DW], ea);
            end
        end
    endtask

    task automatic step(input bit v, input logic [N*DW-1:0] a, input logic [N-1:0] inj,
                        input bit din, input logic [AW-1:0] ps, input string tag);
        @(negedge clk);
        check_outputs();
        wt_load     = 1'b0;
        in_valid    = v;
        act_in      = a;
        inj_in      = inj;
        col_drop_in = din;
        col_psum_in = ps;
        exp_vld[cyc]  = v;
        exp_sum[cyc]  = model_sum(a, inj, din, ps);
        exp_drop[cyc] = v && inj[N-1];
        exp_tag[cyc]  = tag;
        act_hist[cyc] = a;
        if (v) begin
            for (int k = 0; k < N; k++)
                if (inj[k] && cnt_exp[k] < CMAX) cnt_exp[k]++;
        end
    endtask

    task automatic idle_rand();
        step(1'b0, {$urandom, $urandom}, N'($urandom), 1'($urandom), AW'($urandom), "R8");
    endtask

    task automatic drain();
        repeat (N + 3) idle_rand();
    endtask

    task automatic load_weights(input logic [N*DW-1:0] w);
        @(negedge clk);
        check_outputs();
        wt_load  = 1'b1;
        wt_in    = w;
        in_valid = 1'b0;
        inj_in   = '0;
        col_drop_in = 1'b0;
        exp_vld[cyc]  = 1'b0;
        act_hist[cyc] = act_in;
        for (int k = 0; k < N; k++) wmodel[k] = int'($signed(w[k*DW +: DW]));
    endtask

    task automatic check_counts(input string tag);
        for (int k = 0; k < N; k++)
            check(err_cnt_out[k*CW +: CW] == CW'(cnt_exp[k]), tag, err_cnt_out[k*CW +: CW], cnt_exp[k]);
    endtask

    function automatic logic [N*DW-1:0] fill(input int base, input int stride);
        logic [N*DW-1:0] r;
        for (int k = 0; k < N; k++) r[k*DW +: DW] = DW'(base + k * stride);
        return r;
    endfunction

    initial begin
        logic [N*DW-1:0] av;
        void'($urandom(32'd20240611));
        for (int i = 0; i < HIST; i++) begin
            exp_vld[i] = 1'b0; act_hist[i] = '0; exp_sum[i] = '0; exp_drop[i] = 1'b0; exp_tag[i] = "R8";
        end
        for (int k = 0; k < N; k++) begin wmodel[k] = 0; cnt_exp[k] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check(col_valid_out == 1'b0, "R9 valid", col_valid_out, 0);
        check(col_drop_out == 1'b0, "R9 drop", col_drop_out, 0);
        check(col_psum_out == '0, "R9 sum", col_psum_out, 0);
        check(err_cnt_out == '0, "R9 counts", err_cnt_out, 0);

        load_weights(fill(-4, 3));
        av = fill(1, 1);
        step(1'b1, av, '0, 1'b0, 24'd100, "R1 clean");
        drain();
        for (int k = 0; k < N; k++) begin
            step(1'b1, av, N'(1 << k), 1'b0, 24'd7, (k < N - 1) ? "R3 inject" : "R4 last inject");
            drain();
        end
        step(1'b1, av, '0, 1'b1, 24'd5, "R5 top drop");
        drain();
        // R6: back-to-back vectors, adjacent injections on consecutive cycles
        step(1'b1, fill(2, 5), 4'b0001, 1'b0, 24'd1, "R6 stream");
        step(1'b1, fill(-3, 7), 4'b0010, 1'b0, 24'd2, "R6 stream");
        step(1'b1, fill(9, -2), 4'b0011, 1'b1, 24'd3, "R6 stream");
        step(1'b1, fill(4, 1), 4'b1100, 1'b0, 24'd4, "R6 stream");
        drain();
        check_counts("R7 counts directed");
        // R10: extreme weights apply from the next vector on
        load_weights({N{8'h80}});
        step(1'b1, {N{8'h80}}, '0, 1'b0, 24'hFFFFFF, "R10 extreme");
        step(1'b1, {N{8'h7F}}, '0, 1'b0, 24'h000000, "R10 extreme");
        drain();

        for (int ph = 0; ph < 4; ph++) begin
            load_weights({$urandom, $urandom});
            for (int i = 0; i < 150; i++) begin
                bit v = ($urandom % 4) != 0;
                logic [N-1:0] inj;
                for (int k = 0; k < N; k++) inj[k] = ($urandom % 8) == 0;
                step(v, {$urandom, $urandom}, inj, ($urandom % 8) == 0, AW'($urandom), "R6 random");
            end
            drain();
            check_counts("R7 counts random");
        end

        // R7: saturation on element 0
        for (int i = 0; i < CMAX + 4; i++)
            step(1'b1, fill(i, 1), 4'b0001, 1'b0, AW'(i), "R7 saturate");
        drain();
        check_counts("R7 saturation");
        // R8: injections without valid leave counts alone
        repeat (12) step(1'b0, fill(3, 3), '1, 1'b1, 24'd9, "R8 invalid inject");
        drain();
        check_counts("R8 counts unchanged");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule